// File: doc/BRIEF.md
# Platform system control register bank

This block is a byte-wide bank of system-control and identification ports on a simple port bus. A host issues single-cycle read or write strobes with a port address. Reads return fixed board identification and status codes or the value of a stored control field. Writes update a few control bits or fire one-clock strobes toward logic outside the block: soft reset, the two NVRAM protect-lock toggles and the second-level cache invalidate.

One stored bit selects how the system I/O bridge maps addresses, either contiguous or non-contiguous. A four-bit system control field and an activity-light level are also held here. The port bus has no back-pressure: every strobe is accepted in the cycle it is asserted. Read data appears on the clock after the read strobe and stays there until the next read. The strobes and levels that go out of the block are plain pins with no handshake.

Top module: `sysctl_bank`

## Requirements
- R1: A read of any port other than 0x0092, 0x0800, 0x0802, 0x0803, 0x080C, 0x0810, 0x0818, 0x081C, 0x0823 and 0x0850 returns 0xFF. This includes unused ports inside 0x0800..0x0851 and the write-only ports 0x0808, 0x0812 and 0x0814. A write to a port that none of R2 to R9 names changes no output.
- R2: A write to 0x0092 with data bit 0 set raises `soft_reset_pulse` for exactly the one clock after the write. A read of 0x0092 returns 0x00.
- R3: A write to 0x0092 with data bit 1 set raises `endian_fault_pulse` for the one clock after the write, because the little-endian mode is unsupported. Bits 0 and 1 act independently.
- R4: Reads return fixed codes: 0x0800 returns 0xEF, 0x0802 returns 0xAD, 0x0803 returns 0xE0, 0x080C returns 0x3C, 0x0810 returns 0x39, 0x0818 returns 0x00 and 0x0823 returns 0x03. Writes to 0x0800, 0x0802 and 0x0803 leave those codes unchanged.
- R5: Bit 0 of a write to 0x0808 sets (1) or clears (0) `activity_led`. The other data bits are ignored.
- R6: Any write to 0x0810 raises `nvlock1_toggle`, and any write to 0x0812 raises `nvlock2_toggle`, for the clock after the write, whatever the data. Back-to-back writes give a pulse on each clock.
- R7: A write to 0x0814 raises `l2_inval_pulse` for the clock after the write.
- R8: A write to 0x081C stores data bits 3:0 in `sys_ctl`. A read of 0x081C returns that field with bits 7:4 zero.
- R9: A write to 0x0850 stores data bit 0 in `io_map_noncontig` (0 = contiguous, 1 = non-contiguous). A read of 0x0850 returns the stored bit in bit 0, with the other bits zero.
- R10: While `rst_n` is low, every output is 0: the stored bits, all pulses and `port_rdata`.
- R11: `port_rdata` takes the value of the addressed port on the clock edge where `port_rd` is high. It holds that value until the next read. A read in the same cycle as a write returns the value held before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| port_addr | input | 16 | Port address |
| port_rd | input | 1 | Read strobe, one cycle per access |
| port_wr | input | 1 | Write strobe, one cycle per access |
| port_wdata | input | 8 | Write data |
| port_rdata | output | 8 | Read data, valid from the clock after port_rd |
| soft_reset_pulse | output | 1 | Soft reset request strobe |
| endian_fault_pulse | output | 1 | Unsupported little-endian request strobe |
| activity_led | output | 1 | Activity light level |
| nvlock1_toggle | output | 1 | NVRAM protect lock 1 toggle strobe |
| nvlock2_toggle | output | 1 | NVRAM protect lock 2 toggle strobe |
| l2_inval_pulse | output | 1 | Cache invalidate strobe |
| sys_ctl | output | 4 | Stored system control field |
| io_map_noncontig | output | 1 | I/O map mode, 1 = non-contiguous |

## Verification
The assertions check the following on every cycle:
- stored levels change only on a write to their own port;
- the lock and invalidate strobes never overlap;
- reads of unmapped ports return 0xFF;
- unmapped writes fire nothing;
- read data holds when no read is issued.

Only the bench scenarios can show the actual identification code values, the exact data bits each write captures, and the one-clock placement of each strobe. They also cover masking of the upper bits, back-to-back strobes and a reset in the middle of a run. The bench reference model covers these by comparing every output on every clock.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;
  localparam logic [15:0] A_SPECIAL = 16'h0092;
  localparam logic [15:0] A_CPUCFG  = 16'h0800;
  localparam logic [15:0] A_FEAT    = 16'h0802;
  localparam logic [15:0] A_STAT    = 16'h0803;
  localparam logic [15:0] A_LED     = 16'h0808;
  localparam logic [15:0] A_EQUIP   = 16'h080C;
  localparam logic [15:0] A_XFEAT   = 16'h0810;
  localparam logic [15:0] A_LOCK2   = 16'h0812;
  localparam logic [15:0] A_INVAL   = 16'h0814;
  localparam logic [15:0] A_KEY     = 16'h0818;
  localparam logic [15:0] A_SCTL    = 16'h081C;
  localparam logic [15:0] A_L2      = 16'h0823;
  localparam logic [15:0] A_MAP     = 16'h0850;

  localparam logic [7:0] ID_CPUCFG = 8'hEF;
  localparam logic [7:0] ID_FEAT   = 8'hAD;
  localparam logic [7:0] ID_STAT   = 8'hE0;
  localparam logic [7:0] ID_EQUIP  = 8'h3C;
  localparam logic [7:0] ID_XFEAT  = 8'h39;
  localparam logic [7:0] ID_KEY    = 8'h00;
  localparam logic [7:0] ID_L2     = 8'h03;
  localparam logic [7:0] RD_SPECIAL = 8'h00;
  localparam logic [7:0] RD_NONE    = 8'hFF;

  localparam int P_SOFT   = 0;
  localparam int P_ENDIAN = 1;
  localparam int P_LOCK1  = 2;
  localparam int P_LOCK2  = 3;
  localparam int P_INVAL  = 4;
  localparam int NPULSE   = 5;

  typedef struct packed {
    logic special;
    logic cpucfg;
    logic feat;
    logic stat;
    logic led;
    logic equip;
    logic xfeat;
    logic lock2;
    logic inval;
    logic key;
    logic sctl;
    logic l2;
    logic map;
  } sel_t;
endpackage

// File: rtl/sysctl_decode.sv
module sysctl_decode
  import sysctl_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic [ADDR_W-1:0] addr,
  output sel_t              sel
);
  always_comb begin
    sel         = '0;
    sel.special = (addr == ADDR_W'(A_SPECIAL));
    sel.cpucfg  = (addr == ADDR_W'(A_CPUCFG));
    sel.feat    = (addr == ADDR_W'(A_FEAT));
    sel.stat    = (addr == ADDR_W'(A_STAT));
    sel.led     = (addr == ADDR_W'(A_LED));
    sel.equip   = (addr == ADDR_W'(A_EQUIP));
    sel.xfeat   = (addr == ADDR_W'(A_XFEAT));
    sel.lock2   = (addr == ADDR_W'(A_LOCK2));
    sel.inval   = (addr == ADDR_W'(A_INVAL));
    sel.key     = (addr == ADDR_W'(A_KEY));
    sel.sctl    = (addr == ADDR_W'(A_SCTL));
    sel.l2      = (addr == ADDR_W'(A_L2));
    sel.map     = (addr == ADDR_W'(A_MAP));
  end
endmodule

// File: rtl/sysctl_regs.sv
module sysctl_regs
  import sysctl_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int SCTL_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [DATA_W-1:0] wdata,
  input  sel_t              sel,
  output logic              led,
  output logic [SCTL_W-1:0] sctl,
  output logic              map_nc,
  output logic [NPULSE-1:0] pulses
);
  logic [NPULSE-1:0] req;
  logic              unused_bits;

  assign unused_bits = ^{wdata[DATA_W-1:SCTL_W], sel.cpucfg, sel.feat, sel.stat,
                         sel.equip, sel.key, sel.l2};

  always_comb begin
    req           = '0;
    req[P_SOFT]   = wr && sel.special && wdata[0];
    req[P_ENDIAN] = wr && sel.special && wdata[1];
    req[P_LOCK1]  = wr && sel.xfeat;
    req[P_LOCK2]  = wr && sel.lock2;
    req[P_INVAL]  = wr && sel.inval;
  end

  for (genvar i = 0; i < NPULSE; i++) begin : g_pulse
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pulses[i] <= 1'b0;
      else        pulses[i] <= req[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      led    <= 1'b0;
      sctl   <= '0;
      map_nc <= 1'b0;
    end else if (wr) begin
      if (sel.led)  led    <= wdata[0];
      if (sel.sctl) sctl   <= wdata[SCTL_W-1:0];
      if (sel.map)  map_nc <= wdata[0];
    end
  end

  p_led_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr && sel.led) |=> $stable(led));
  p_sctl_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr && sel.sctl) |=> $stable(sctl));
  p_map_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr && sel.map) |=> $stable(map_nc));
  p_strobe_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(pulses[P_INVAL:P_LOCK1]));
endmodule

// File: rtl/sysctl_rdmux.sv
module sysctl_rdmux
  import sysctl_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int SCTL_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd,
  input  sel_t              sel,
  input  logic [SCTL_W-1:0] sctl,
  input  logic              map_nc,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] rd_next;
  logic              unused_sel;

  assign unused_sel = ^{sel.led, sel.lock2, sel.inval};

  always_comb begin
    rd_next = DATA_W'(RD_NONE);
    unique case (1'b1)
      sel.special: rd_next = DATA_W'(RD_SPECIAL);
      sel.cpucfg:  rd_next = DATA_W'(ID_CPUCFG);
      sel.feat:    rd_next = DATA_W'(ID_FEAT);
      sel.stat:    rd_next = DATA_W'(ID_STAT);
      sel.equip:   rd_next = DATA_W'(ID_EQUIP);
      sel.xfeat:   rd_next = DATA_W'(ID_XFEAT);
      sel.key:     rd_next = DATA_W'(ID_KEY);
      sel.l2:      rd_next = DATA_W'(ID_L2);
      sel.sctl:    rd_next = DATA_W'(sctl);
      sel.map:     rd_next = DATA_W'(map_nc);
      default:     rd_next = DATA_W'(RD_NONE);
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  rdata <= '0;
    else if (rd) rdata <= rd_next;
  end

  p_rd_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !rd |=> $stable(rdata));
  p_sctl_upper_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && sel.sctl) |=> (rdata[DATA_W-1:SCTL_W] == '0));
  p_map_upper_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && sel.map) |=> (rdata[DATA_W-1:1] == '0));
endmodule

// File: rtl/sysctl_bank.sv
module sysctl_bank
  import sysctl_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int SCTL_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] port_addr,
  input  logic              port_rd,
  input  logic              port_wr,
  input  logic [DATA_W-1:0] port_wdata,
  output logic [DATA_W-1:0] port_rdata,
  output logic              soft_reset_pulse,
  output logic              endian_fault_pulse,
  output logic              activity_led,
  output logic              nvlock1_toggle,
  output logic              nvlock2_toggle,
  output logic              l2_inval_pulse,
  output logic [SCTL_W-1:0] sys_ctl,
  output logic              io_map_noncontig
);
  sel_t              sel;
  logic [NPULSE-1:0] pulses;

  sysctl_decode #(.ADDR_W(ADDR_W)) u_decode (
    .addr (port_addr),
    .sel  (sel)
  );

  sysctl_regs #(.DATA_W(DATA_W), .SCTL_W(SCTL_W)) u_regs (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr     (port_wr),
    .wdata  (port_wdata),
    .sel    (sel),
    .led    (activity_led),
    .sctl   (sys_ctl),
    .map_nc (io_map_noncontig),
    .pulses (pulses)
  );

  sysctl_rdmux #(.DATA_W(DATA_W), .SCTL_W(SCTL_W)) u_rdmux (
    .clk    (clk),
    .rst_n  (rst_n),
    .rd     (port_rd),
    .sel    (sel),
    .sctl   (sys_ctl),
    .map_nc (io_map_noncontig),
    .rdata  (port_rdata)
  );

  assign soft_reset_pulse   = pulses[P_SOFT];
  assign endian_fault_pulse = pulses[P_ENDIAN];
  assign nvlock1_toggle     = pulses[P_LOCK1];
  assign nvlock2_toggle     = pulses[P_LOCK2];
  assign l2_inval_pulse     = pulses[P_INVAL];

  p_unmapped_read_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (port_rd && sel == '0) |=> (port_rdata == DATA_W'(RD_NONE)));
  p_unmapped_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (port_wr && sel == '0) |=> (pulses == '0));
endmodule

// File: tb/sysctl_bank_bench.sv
module sysctl_bank_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] port_addr = 16'h0000;
  logic        port_rd = 1'b0;
  logic        port_wr = 1'b0;
  logic [7:0]  port_wdata = 8'h00;
  logic [7:0]  port_rdata;
  logic        soft_reset_pulse, endian_fault_pulse, activity_led;
  logic        nvlock1_toggle, nvlock2_toggle, l2_inval_pulse, io_map_noncontig;
  logic [3:0]  sys_ctl;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  sysctl_bank u_sysctl_bank (
    .clk(clk), .rst_n(rst_n), .port_addr(port_addr), .port_rd(port_rd),
    .port_wr(port_wr), .port_wdata(port_wdata), .port_rdata(port_rdata),
    .soft_reset_pulse(soft_reset_pulse), .endian_fault_pulse(endian_fault_pulse),
    .activity_led(activity_led), .nvlock1_toggle(nvlock1_toggle),
    .nvlock2_toggle(nvlock2_toggle), .l2_inval_pulse(l2_inval_pulse),
    .sys_ctl(sys_ctl), .io_map_noncontig(io_map_noncontig)
  );

  // behavioural reference model
  logic [7:0] m_rd;
  logic       m_led, m_map, m_soft, m_end, m_l1, m_l2, m_inv;
  logic [3:0] m_sctl;

  function automatic logic [7:0] spec_read(input logic [15:0] a);
    case (a)
      16'h0092: return 8'h00;
      16'h0800: return 8'hEF;
      16'h0802: return 8'hAD;
      16'h0803: return 8'hE0;
      16'h080C: return 8'h3C;
      16'h0810: return 8'h39;
      16'h0818: return 8'h00;
      16'h0823: return 8'h03;
      16'h081C: return {4'h0, m_sctl};
      16'h0850: return {7'h00, m_map};
      default:  return 8'hFF;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_rd <= 8'h00; m_led <= 1'b0; m_map <= 1'b0; m_sctl <= 4'h0;
      m_soft <= 1'b0; m_end <= 1'b0; m_l1 <= 1'b0; m_l2 <= 1'b0; m_inv <= 1'b0;
    end else begin
      m_soft <= port_wr && port_addr == 16'h0092 && port_wdata[0];
      m_end  <= port_wr && port_addr == 16'h0092 && port_wdata[1];
      m_l1   <= port_wr && port_addr == 16'h0810;
      m_l2   <= port_wr && port_addr == 16'h0812;
      m_inv  <= port_wr && port_addr == 16'h0814;
      if (port_rd) m_rd <= spec_read(port_addr);
      if (port_wr) begin
        if (port_addr == 16'h0808) m_led  <= port_wdata[0];
        if (port_addr == 16'h081C) m_sctl <= port_wdata[3:0];
        if (port_addr == 16'h0850) m_map  <= port_wdata[0];
      end
    end
  end

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!done) begin
      chk("R11 rdata model", port_rdata, m_rd);
      chk("R2 soft model", {7'h0, soft_reset_pulse}, {7'h0, m_soft});
      chk("R3 endian model", {7'h0, endian_fault_pulse}, {7'h0, m_end});
      chk("R5 led model", {7'h0, activity_led}, {7'h0, m_led});
      chk("R6 lock1 model", {7'h0, nvlock1_toggle}, {7'h0, m_l1});
      chk("R6 lock2 model", {7'h0, nvlock2_toggle}, {7'h0, m_l2});
      chk("R7 inval model", {7'h0, l2_inval_pulse}, {7'h0, m_inv});
      chk("R8 sctl model", {4'h0, sys_ctl}, {4'h0, m_sctl});
      chk("R9 map model", {7'h0, io_map_noncontig}, {7'h0, m_map});
    end
  end

  task automatic wr_port(input logic [15:0] a, input logic [7:0] d);
    port_addr = a; port_wdata = d; port_wr = 1'b1;
    @(negedge clk);
    port_wr = 1'b0;
  endtask

  task automatic rd_port(input logic [15:0] a, output logic [7:0] v);
    port_addr = a; port_rd = 1'b1;
    @(negedge clk);
    port_rd = 1'b0;
    v = port_rdata;
  endtask

  function automatic logic [7:0] pulse_vec();
    return {3'b0, l2_inval_pulse, nvlock2_toggle, nvlock1_toggle,
            endian_fault_pulse, soft_reset_pulse};
  endfunction

  task automatic finish_run();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [7:0] v;
    @(negedge clk); @(negedge clk);
    chk("R10 reset rdata", port_rdata, 8'h00);
    chk("R10 reset levels", {activity_led, io_map_noncontig, 2'b0, sys_ctl}, 8'h00);
    chk("R10 reset pulses", pulse_vec(), 8'h00);
    rst_n = 1'b1;
    @(negedge clk);

    rd_port(16'h0800, v); chk("R4 0800", v, 8'hEF);
    rd_port(16'h0802, v); chk("R4 0802", v, 8'hAD);
    rd_port(16'h0803, v); chk("R4 0803", v, 8'hE0);
    rd_port(16'h080C, v); chk("R4 080C", v, 8'h3C);
    rd_port(16'h0810, v); chk("R4 0810", v, 8'h39);
    rd_port(16'h0818, v); chk("R4 0818", v, 8'h00);
    rd_port(16'h0823, v); chk("R4 0823", v, 8'h03);
    rd_port(16'h0092, v); chk("R2 read 0092", v, 8'h00);
    rd_port(16'h0814, v); chk("R7 read 0814", v, 8'hFF);
    rd_port(16'h0851, v); chk("R1 read 0851", v, 8'hFF);
    rd_port(16'h1234, v); chk("R1 read 1234", v, 8'hFF);
    rd_port(16'h0808, v); chk("R1 read 0808", v, 8'hFF);
    @(negedge clk);
    chk("R11 hold", port_rdata, 8'hFF);

    wr_port(16'h0800, 8'h00);
    wr_port(16'h0803, 8'h55);
    rd_port(16'h0800, v); chk("R4 0800 after write", v, 8'hEF);
    rd_port(16'h0803, v); chk("R4 0803 after write", v, 8'hE0);

    wr_port(16'h0808, 8'h01); chk("R5 led set", {7'h0, activity_led}, 8'h01);
    wr_port(16'h0808, 8'hFE); chk("R5 led clear", {7'h0, activity_led}, 8'h00);
    wr_port(16'h0808, 8'h03);

    wr_port(16'h081C, 8'hAB); chk("R8 sctl field", {4'h0, sys_ctl}, 8'h0B);
    rd_port(16'h081C, v); chk("R8 sctl read", v, 8'h0B);

    wr_port(16'h0850, 8'hFF); chk("R9 map set", {7'h0, io_map_noncontig}, 8'h01);
    rd_port(16'h0850, v); chk("R9 map read", v, 8'h01);

    wr_port(16'h1234, 8'hFF); chk("R1 unmapped write pulses", pulse_vec(), 8'h00);
    wr_port(16'h0851, 8'h00);
    chk("R1 unmapped write levels", {activity_led, io_map_noncontig, 2'b0, sys_ctl}, 8'hCB);

    wr_port(16'h0850, 8'h02); chk("R9 map clear", {7'h0, io_map_noncontig}, 8'h00);

    wr_port(16'h0092, 8'h01); chk("R2 soft pulse", pulse_vec(), 8'h01);
    @(negedge clk);           chk("R2 soft one cycle", pulse_vec(), 8'h00);
    wr_port(16'h0092, 8'h02); chk("R3 endian only", pulse_vec(), 8'h02);
    wr_port(16'h0092, 8'h03); chk("R3 both bits", pulse_vec(), 8'h03);
    wr_port(16'h0810, 8'h00); chk("R6 lock1 zero data", pulse_vec(), 8'h04);
    wr_port(16'h0810, 8'hFF); chk("R6 lock1 back to back", pulse_vec(), 8'h04);
    wr_port(16'h0812, 8'h5A); chk("R6 lock2", pulse_vec(), 8'h08);
    wr_port(16'h0814, 8'h00); chk("R7 inval", pulse_vec(), 8'h10);
    @(negedge clk);           chk("R7 inval one cycle", pulse_vec(), 8'h00);

    port_addr = 16'h081C; port_wdata = 8'h06; port_rd = 1'b1; port_wr = 1'b1;
    @(negedge clk);
    port_rd = 1'b0; port_wr = 1'b0;
    chk("R11 read during write old", port_rdata, 8'h0B);
    chk("R8 sctl updated", {4'h0, sys_ctl}, 8'h06);

    wr_port(16'h0850, 8'h01);
    rst_n = 1'b0;
    #1;
    chk("R10 midrun levels", {activity_led, io_map_noncontig, 2'b0, sys_ctl}, 8'h00);
    chk("R10 midrun rdata", port_rdata, 8'h00);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    rd_port(16'h0850, v); chk("R9 reset contiguous", v, 8'h00);
    @(negedge clk);
    finish_run();
  end
endmodule